// File: doc/BRIEF.md
# Overcurrent Fault Sequencer with Hiccup Retry

This block is the per-channel protection sequencer of a switching regulator controller. It watches a peak-overcurrent comparator on every switching cycle and blanks the high-side switch from the moment of detection until the next cycle begins. It also counts how many consecutive cycles show the fault. When that run grows too long, it shuts the channel down. It then waits a fixed number of soft-start periods before it clears its counts and requests a fresh soft-start.

A second path handles a negative-current limit. It stops all switching, puts the output stage into a high-impedance state and asks for the output pull-down. Switching resumes once the output is reported back in regulation. All sensing and thresholds are outside the block: it sees only digital flags and strobes. A low channel enable returns it to an idle, discharged state at any time.

Top module: `ocp_hiccup_seq`

## Requirements
- R1: While `en_i` is low, and out of reset, `shutdown_o` and `discharge_o` are 1 and `tristate_o`, `hs_kill_o`, `ss_restart_o` and `oc_flag_o` are 0 from the next clock edge on.
- R2: In the cycle after `en_i` is sampled high in the idle state, the channel runs. In that cycle `shutdown_o` and `discharge_o` are 0 and `ss_restart_o` is 1, for exactly one cycle.
- R3: While running, `hs_kill_o` follows `oc_i` with no clock delay. It then stays 1 for the rest of that switching cycle. It drops in the cycle where `cyc_start_i` is 1, unless `oc_i` is also 1 in that cycle, which counts as detection in the new cycle.
- R4: The first overcurrent detection in a switching cycle increments the fault count. `oc_flag_o` (count non-zero) is 1 from the next edge.
- R5: On a `cyc_start_i` that closes a switching cycle with no detection, the count clears and `oc_flag_o` is 0 from the next edge.
- R6: The 17th detection in consecutive switching cycles enters hiccup. From the next edge `shutdown_o` and `discharge_o` are 1, and `oc_flag_o` stays 1.
- R7: In hiccup, the 4th `ss_tick_i` clears the count and returns the channel to running at the next edge, with a one-cycle `ss_restart_o` pulse. Fewer ticks keep it shut down.
- R8: While running, `neg_oc_i` makes `tristate_o` and `discharge_o` 1 and `shutdown_o` 0 from the next edge. This holds until `in_reg_i` is sampled 1, after which it runs again with no `ss_restart_o` pulse.
- R9: If `neg_oc_i` arrives in the same cycle as the 17th detection, the tri-state path is taken first. Once `in_reg_i` is sampled, the channel goes to hiccup (`shutdown_o` = 1).
- R10: `en_i` low clears the fault count. After re-enable, a fresh run of 17 detections is needed to shut down.
- R11: Outside the running state, `oc_i` and `cyc_start_i` have no effect: `hs_kill_o` stays 0 and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| cyc_start_i | input | 1 | One-cycle strobe at the start of each switching cycle |
| oc_i | input | 1 | Peak overcurrent comparator flag |
| neg_oc_i | input | 1 | Negative current limit flag |
| in_reg_i | input | 1 | Output back in regulation |
| ss_tick_i | input | 1 | One-cycle strobe per soft-start period |
| hs_kill_o | output | 1 | Force the high-side switch off |
| shutdown_o | output | 1 | Channel shut down |
| tristate_o | output | 1 | Both power switches off |
| discharge_o | output | 1 | Enable output pull-down |
| ss_restart_o | output | 1 | Start a soft-start ramp |
| oc_flag_o | output | 1 | Overcurrent condition present |

## Verification
A fault count that is off by one shows up as a shutdown one switching cycle early or late in the run of 17. A count that fails to clear shows up as a premature hiccup after a clean cycle. Either error becomes visible at `shutdown_o` within the cycle after the detection that should or should not have tripped. A wrong hiccup tick count moves the `ss_restart_o` pulse by one soft-start period. A lost pending fault across the tri-state episode appears as running (`shutdown_o` low) instead of hiccup, in the edge after `in_reg_i`. The reference model is compared on every clock, so any of these shows up in the first cycle it differs.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NEG  = 2'd2,
    ST_HIC  = 2'd3
  } ocp_state_e;
endpackage

// File: rtl/ocp_run_counter.sv
module ocp_run_counter #(
  parameter int LIMIT = 17,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          act_i,
  input  logic          cyc_start_i,
  input  logic          oc_i,
  output logic [CW-1:0] cnt_o,
  output logic          kill_o,
  output logic          limit_o
);
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          kill_q, kill_d, hit;

  // detection: first oc in a cycle; oc on the start strobe belongs to the new cycle
  assign hit  = act_i & oc_i & (cyc_start_i | ~kill_q);
  assign base = (act_i & cyc_start_i & ~kill_q) ? '0 : cnt_q;
  assign cnt_d = hit ? base + CW'(1) : base;

  always_comb begin
    kill_d = kill_q;
    if (act_i) kill_d = cyc_start_i ? oc_i : (kill_q | oc_i);
  end

  assign limit_o = hit & (cnt_d == CW'(LIMIT));
  assign kill_o  = act_i & (oc_i | (kill_q & ~cyc_start_i));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kill_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      kill_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      kill_q <= kill_d;
    end
  end
endmodule

// File: rtl/ocp_wait_timer.sv
module ocp_wait_timer #(
  parameter int PERIODS = 4,
  parameter int TW      = $clog2(PERIODS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  logic [TW-1:0] cnt_q;

  assign done_o = run_i & tick_i & (cnt_q == TW'(PERIODS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/ocp_seq_ctrl.sv
module ocp_seq_ctrl
  import ocp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       neg_oc_i,
  input  logic       in_reg_i,
  input  logic       limit_i,
  input  logic       wait_done_i,
  output ocp_state_e state_o,
  output logic       restart_o
);
  ocp_state_e st_q, st_d;
  logic       pend_q, pend_d, restart_q, restart_d;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    if (!en_i) begin
      st_d   = ST_IDLE;
      pend_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_RUN;
        ST_RUN: begin
          // negative current wins; a coincident fault is kept for later
          if (neg_oc_i) begin
            st_d   = ST_NEG;
            pend_d = limit_i;
          end else if (limit_i) begin
            st_d = ST_HIC;
          end
        end
        ST_NEG: begin
          if (in_reg_i) begin
            st_d   = pend_q ? ST_HIC : ST_RUN;
            pend_d = 1'b0;
          end
        end
        ST_HIC: if (wait_done_i) st_d = ST_RUN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign restart_d = en_i & ((st_q == ST_IDLE) | ((st_q == ST_HIC) & wait_done_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pend_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_q    <= pend_d;
      restart_q <= restart_d;
    end
  end

  assign state_o   = st_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq
  import ocp_pkg::*;
#(
  parameter int OC_LIMIT     = 17,
  parameter int WAIT_PERIODS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cyc_start_i,
  input  logic oc_i,
  input  logic neg_oc_i,
  input  logic in_reg_i,
  input  logic ss_tick_i,
  output logic hs_kill_o,
  output logic shutdown_o,
  output logic tristate_o,
  output logic discharge_o,
  output logic ss_restart_o,
  output logic oc_flag_o
);
  localparam int CNT_W = $clog2(OC_LIMIT + 1);
  localparam int TMR_W = $clog2(WAIT_PERIODS + 1);

  ocp_state_e       state;
  logic [CNT_W-1:0] oc_cnt;
  logic             limit_hit, wait_done, kill;

  ocp_run_counter #(.LIMIT(OC_LIMIT), .CW(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (~en_i | wait_done),
    .act_i       (state == ST_RUN),
    .cyc_start_i (cyc_start_i),
    .oc_i        (oc_i),
    .cnt_o       (oc_cnt),
    .kill_o      (kill),
    .limit_o     (limit_hit)
  );

  ocp_wait_timer #(.PERIODS(WAIT_PERIODS), .TW(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state == ST_HIC),
    .tick_i (ss_tick_i),
    .done_o (wait_done)
  );

  ocp_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .neg_oc_i    (neg_oc_i),
    .in_reg_i    (in_reg_i),
    .limit_i     (limit_hit),
    .wait_done_i (wait_done),
    .state_o     (state),
    .restart_o   (ss_restart_o)
  );

  assign hs_kill_o   = kill;
  assign shutdown_o  = (state == ST_IDLE) | (state == ST_HIC);
  assign tristate_o  = (state == ST_NEG);
  assign discharge_o = (state != ST_RUN);
  assign oc_flag_o   = |oc_cnt;
endmodule

// File: rtl/ocp_hiccup_seq_chk.sv
module ocp_hiccup_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic oc_i,
  input logic neg_oc_i,
  input logic in_reg_i,
  input logic hs_kill_o,
  input logic shutdown_o,
  input logic tristate_o,
  input logic discharge_o,
  input logic ss_restart_o,
  input logic oc_flag_o
);
  a_r1_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> shutdown_o && discharge_o && !tristate_o);
  a_r10_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !oc_flag_o);
  a_r2_restart_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_restart_o |=> !ss_restart_o);
  a_r7_restart_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_restart_o |-> !shutdown_o && !tristate_o && !oc_flag_o);
  a_r3_kill_on_oc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_i && !shutdown_o && !tristate_o) |-> hs_kill_o);
  a_r11_no_kill_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o || tristate_o) |-> !hs_kill_o);
  a_r8_enter_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && neg_oc_i && !shutdown_o && !tristate_o) |=> tristate_o);
  a_r8_tristate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tristate_o && !in_reg_i) |=> tristate_o);
  a_r8_tristate_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tristate_o |-> discharge_o && !shutdown_o);
endmodule

bind ocp_hiccup_seq ocp_hiccup_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .oc_i         (oc_i),
  .neg_oc_i     (neg_oc_i),
  .in_reg_i     (in_reg_i),
  .hs_kill_o    (hs_kill_o),
  .shutdown_o   (shutdown_o),
  .tristate_o   (tristate_o),
  .discharge_o  (discharge_o),
  .ss_restart_o (ss_restart_o),
  .oc_flag_o    (oc_flag_o)
);

// File: tb/ocp_hiccup_seq_test.sv
`timescale 1ns/1ps
module ocp_hiccup_seq_test;
  localparam int LIM  = 17;
  localparam int WAIT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, cs = 1'b0, oc = 1'b0, ng = 1'b0, rg = 1'b0, tk = 1'b0;
  logic hs_kill, shutdown, tristate, discharge, restart, flag;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 run, 2 negative, 3 hiccup
  int m_st = 0, m_cnt = 0, m_tk = 0;
  bit m_kq = 0, m_pend = 0, m_rs = 0;

  always #2.5 clk = ~clk;

  ocp_hiccup_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cyc_start_i(cs), .oc_i(oc),
    .neg_oc_i(ng), .in_reg_i(rg), .ss_tick_i(tk),
    .hs_kill_o(hs_kill), .shutdown_o(shutdown), .tristate_o(tristate),
    .discharge_o(discharge), .ss_restart_o(restart), .oc_flag_o(flag)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_ni) begin
      bit nrs, hitm, lim;
      nrs = en && (m_st == 0 || (m_st == 3 && tk && m_tk == WAIT - 1));
      if (!en) begin
        m_st = 0; m_cnt = 0; m_kq = 0; m_pend = 0; m_tk = 0;
      end else begin
        case (m_st)
          0: begin m_st = 1; m_tk = 0; end
          1: begin
            m_tk = 0;
            hitm = oc && (cs || !m_kq);
            if (cs && !m_kq) m_cnt = 0;
            if (hitm) m_cnt++;
            m_kq = cs ? oc : (m_kq || oc);
            lim = hitm && (m_cnt == LIM);
            if (ng) begin m_st = 2; m_pend = lim; end
            else if (lim) m_st = 3;
          end
          2: begin
            m_tk = 0;
            if (rg) begin m_st = m_pend ? 3 : 1; m_pend = 0; end
          end
          default: if (tk) begin
            if (m_tk == WAIT - 1) begin m_st = 1; m_cnt = 0; m_kq = 0; m_tk = 0; end
            else m_tk++;
          end
        endcase
      end
      m_rs = nrs;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      check("R3 hs_kill model", hs_kill, (m_st == 1) && (oc || (m_kq && !cs)));
      check("R6 shutdown model", shutdown, (m_st == 0) || (m_st == 3));
      check("R8 tristate model", tristate, m_st == 2);
      check("R1 discharge model", discharge, m_st != 1);
      check("R7 restart model", restart, m_rs);
      check("R4 oc_flag model", flag, m_cnt != 0);
    end
  end

  task automatic step(input logic c, input logic o, input logic n, input logic r, input logic t);
    @(posedge clk); #1;
    cs = c; oc = o; ng = n; rg = r; tk = t;
  endtask

  task automatic sw_cycle(input logic o);
    step(1, 0, 0, 0, 0);
    step(0, o, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(50000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R1 shutdown idle", shutdown, 1'b1);
    check("R1 discharge idle", discharge, 1'b1);
    check("R1 flag idle", flag, 1'b0);

    // R2: enable
    @(posedge clk); #1 en = 1'b1;
    @(negedge clk);
    check("R2 still idle", shutdown, 1'b1);
    @(negedge clk);
    check("R2 restart pulse", restart, 1'b1);
    check("R2 running", shutdown, 1'b0);
    @(negedge clk);
    check("R2 pulse ends", restart, 1'b0);

    // R3/R4/R5
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    @(negedge clk);
    check("R3 kill immediate", hs_kill, 1'b1);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R3 kill held", hs_kill, 1'b1);
    check("R4 flag raised", flag, 1'b1);
    step(1, 0, 0, 0, 0);
    @(negedge clk);
    check("R3 kill released", hs_kill, 1'b0);
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R5 flag cleared", flag, 1'b0);

    // R6
    for (int i = 0; i < LIM - 1; i++) sw_cycle(1);
    @(negedge clk);
    check("R6 not yet", shutdown, 1'b0);
    sw_cycle(1);
    @(negedge clk);
    check("R6 shutdown", shutdown, 1'b1);
    check("R6 discharge", discharge, 1'b1);
    check("R6 flag held", flag, 1'b1);

    // R11: oc ignored in hiccup
    step(1, 1, 0, 0, 0);
    @(negedge clk);
    check("R11 no kill in hiccup", hs_kill, 1'b0);
    step(0, 0, 0, 0, 0);

    // R7
    for (int i = 0; i < WAIT - 1; i++) begin
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
    end
    @(negedge clk);
    check("R7 still waiting", shutdown, 1'b1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R7 restart", restart, 1'b1);
    check("R7 running", shutdown, 1'b0);
    check("R7 flag clear", flag, 1'b0);

    // R8
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8 tristate", tristate, 1'b1);
    check("R8 discharge", discharge, 1'b1);
    check("R8 not shutdown", shutdown, 1'b0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8 tristate held", tristate, 1'b1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8 resumed", tristate, 1'b0);
    check("R8 no restart", restart, 1'b0);
    check("R8 running", discharge, 1'b0);

    // R9
    for (int i = 0; i < LIM - 1; i++) sw_cycle(1);
    step(1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9 tristate first", tristate, 1'b1);
    check("R9 flag", flag, 1'b1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R9 hiccup after", shutdown, 1'b1);
    for (int i = 0; i < WAIT; i++) begin
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
    end
    @(negedge clk);
    check("R9 recovered", shutdown, 1'b0);

    // R10
    for (int i = 0; i < 3; i++) sw_cycle(1);
    @(negedge clk);
    check("R10 flag before", flag, 1'b1);
    @(posedge clk); #1 en = 1'b0;
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R10 flag cleared", flag, 1'b0);
    check("R10 shutdown", shutdown, 1'b1);
    @(posedge clk); #1 en = 1'b1;
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < LIM - 1; i++) sw_cycle(1);
    @(negedge clk);
    check("R10 fresh run", shutdown, 1'b0);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule